// File: doc/BRIEF.md
# Commutated Output-Control Shadow Register

This block keeps two copies of the control word of each output channel of a multi-channel compare unit. Each control word has three fields: a main output enable, a complementary output enable, and an output mode. One copy, the shadow, receives every register write. The other copy, the active set, drives the channel outputs.

When the buffering switch is off, writes pass straight to the active set. When it is on, writes stay in the shadow. They move to the active set for all channels together, and only on a commutation event. That event lets a motor-drive controller load the next phase pattern at any time and apply it at a precise instant.

A commutation event comes from a one-cycle software strobe. When the source select is 1, a rising edge on an external trigger line also counts. Every event sets a sticky flag, which a write-one-to-clear pulse removes.

The write port is a valid/ready stream. Ready is held high at all times, so the block never exerts back-pressure. A beat is taken on every cycle in which valid is high.

Top module: `ccp_preload_ctl`

## Requirements
- R1: After reset, every active enable, complementary enable and mode field is 0, every shadow field is 0, and the event flag is 0.
- R2: With buffering off (`pl_en`=0), an accepted write to channel `wr_ch` (binary index) appears on that channel's active outputs one cycle later. The other channels keep their values.
- R3: With buffering on and no commutation event, the active outputs do not change, whatever is written.
- R4: With `trig_sel`=0, a `sw_com` pulse copies every channel's shadow word into the active set. A rising edge on `trig_in` copies nothing.
- R5: With `trig_sel`=1, a rising edge on `trig_in` also copies the shadow set into the active set.
- R6: Trigger edges are found against the trigger level registered in the previous cycle, which is 0 after reset. A trigger held high therefore causes only one event.
- R7: When a write and a commutation event fall in the same cycle with buffering on, the active set takes the shadow contents from before that write. The new value stays in the shadow until the next event.
- R8: Every commutation event sets `com_flag`, whether buffering is on or off. The flag holds until a cycle with `flag_clr`=1 and no event, which clears it. An event in the same cycle as a clear wins.
- R9: In the first cycle with `pl_en`=0 after a cycle with `pl_en`=1, the whole shadow set is copied to the active set. A write accepted in that same cycle overrides the copy for its own channel.
- R10: `wr_ready` is 1 in every cycle, including during reset.
- R11: Mode values use all 3 bits: each channel's `act_mode` field at bits [3c+2:3c] reproduces any written value 0..7. The three fields of a channel are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, held high |
| wr_ch | input | CH_W | Channel index of the write |
| wr_oe | input | 1 | Written main output enable |
| wr_oen | input | 1 | Written complementary output enable |
| wr_mode | input | 3 | Written output mode |
| pl_en | input | 1 | Buffering switch (1 = hold writes until commutation) |
| trig_sel | input | 1 | Event source select (1 = trigger edge also counts) |
| sw_com | input | 1 | Software commutation strobe |
| trig_in | input | 1 | External trigger level |
| flag_clr | input | 1 | Write-one-to-clear for the event flag |
| act_oe | output | NUM_CH | Active main output enables, bit c = channel c |
| act_oen | output | NUM_CH | Active complementary enables, bit c = channel c |
| act_mode | output | 3*NUM_CH | Active modes, channel c at [3c+2:3c] |
| com_flag | output | 1 | Sticky commutation-event flag |

## Verification
The bench aims at the cases where old and new values meet.

- A write and a strobe in the same cycle: a design that forwards the fresh write to the active outputs fails R7.
- A trigger held high across several cycles: a design that detects the level instead of the edge transfers again and fails R6.
- Turning buffering off together with a write: a design that lets the copy override the write, or that skips the copy, leaves wrong words behind (R9).
- A clear arriving together with an event: a design that gives the clear priority loses the event (R8).

Sweeps over every channel and every 5-bit control word expose crossed channel indices and swapped field positions.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int MODE_W = 3;
  localparam int WORD_W = MODE_W + 2;

  typedef struct packed {
    logic              oe;
    logic              oen;
    logic [MODE_W-1:0] mode;
  } ctl_t;

  localparam ctl_t CTL_ZERO = '{oe: 1'b0, oen: 1'b0, mode: '0};
endpackage

// File: rtl/ccp_com_detect.sv
module ccp_com_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_com,
  input  logic trig_sel,
  input  logic trig_in,
  output logic com_evt
);
  logic trig_q;
  logic trig_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign trig_rise = trig_in & ~trig_q;
  assign com_evt   = sw_com | (trig_sel & trig_rise);
endmodule

// File: rtl/ccp_com_flag.sv
module ccp_com_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic com_evt,
  input  logic flag_clr,
  output logic com_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        com_flag <= 1'b0;
    else if (com_evt)  com_flag <= 1'b1;
    else if (flag_clr) com_flag <= 1'b0;
  end
endmodule

// File: rtl/ccp_ctl_bank.sv
module ccp_ctl_bank
  import ccp_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_hit,
  input  logic [CH_W-1:0]         wr_ch,
  input  ctl_t                    wr_word,
  input  logic                    pl_en,
  input  logic                    pl_fall,
  input  logic                    com_evt,
  output ctl_t [NUM_CH-1:0]       act_o
);
  ctl_t [NUM_CH-1:0] shadow_q;
  ctl_t [NUM_CH-1:0] active_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_c;
    ctl_t act_nxt;

    assign sel_c = wr_hit && (wr_ch == CH_W'(c));

    always_comb begin
      act_nxt = active_q[c];
      if (!pl_en) begin
        if (pl_fall) act_nxt = shadow_q[c];
        if (sel_c)   act_nxt = wr_word;
      end else if (com_evt) begin
        act_nxt = shadow_q[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[c] <= CTL_ZERO;
        active_q[c] <= CTL_ZERO;
      end else begin
        if (sel_c) shadow_q[c] <= wr_word;
        active_q[c] <= act_nxt;
      end
    end
  end

  assign act_o = active_q;
endmodule

// File: rtl/ccp_preload_ctl.sv
module ccp_preload_ctl
  import ccp_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic                     wr_oe,
  input  logic                     wr_oen,
  input  logic [MODE_W-1:0]        wr_mode,
  input  logic                     pl_en,
  input  logic                     trig_sel,
  input  logic                     sw_com,
  input  logic                     trig_in,
  input  logic                     flag_clr,
  output logic [NUM_CH-1:0]        act_oe,
  output logic [NUM_CH-1:0]        act_oen,
  output logic [NUM_CH*MODE_W-1:0] act_mode,
  output logic                     com_flag
);
  logic              com_evt;
  logic              pl_q;
  logic              pl_fall;
  logic              wr_hit;
  ctl_t              wr_word;
  ctl_t [NUM_CH-1:0] act_w;

  assign wr_ready = 1'b1;
  assign wr_hit   = wr_valid & wr_ready & (32'(wr_ch) < NUM_CH);
  assign wr_word  = '{oe: wr_oe, oen: wr_oen, mode: wr_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pl_q <= 1'b0;
    else        pl_q <= pl_en;
  end
  assign pl_fall = pl_q & ~pl_en;

  ccp_com_detect det_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_com   (sw_com),
    .trig_sel (trig_sel),
    .trig_in  (trig_in),
    .com_evt  (com_evt)
  );

  ccp_ctl_bank #(.NUM_CH(NUM_CH)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_ch   (wr_ch),
    .wr_word (wr_word),
    .pl_en   (pl_en),
    .pl_fall (pl_fall),
    .com_evt (com_evt),
    .act_o   (act_w)
  );

  ccp_com_flag flag_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .com_evt  (com_evt),
    .flag_clr (flag_clr),
    .com_flag (com_flag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign act_oe[c]                      = act_w[c].oe;
    assign act_oen[c]                     = act_w[c].oen;
    assign act_mode[c*MODE_W +: MODE_W]   = act_w[c].mode;
  end
endmodule

// File: rtl/ccp_preload_ctl_chk.sv
module ccp_preload_ctl_chk
  import ccp_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic [CH_W-1:0]          wr_ch,
  input logic                     wr_oe,
  input logic                     pl_en,
  input logic                     flag_clr,
  input logic                     com_evt,
  input logic [NUM_CH-1:0]        act_oe,
  input logic [NUM_CH-1:0]        act_oen,
  input logic [NUM_CH*MODE_W-1:0] act_mode,
  input logic                     com_flag
);
  logic [NUM_CH*(MODE_W+2)-1:0] act_all;
  assign act_all = {act_oe, act_oen, act_mode};

  // R3
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && !com_evt) |=> $stable(act_all));

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !pl_en && (32'(wr_ch) < NUM_CH))
      |=> (act_oe[$past(wr_ch)] == $past(wr_oe)));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> com_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !com_evt) |=> !com_flag);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && !com_evt) |=> $stable(com_flag));
endmodule

bind ccp_preload_ctl ccp_preload_ctl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_ch    (wr_ch),
  .wr_oe    (wr_oe),
  .pl_en    (pl_en),
  .flag_clr (flag_clr),
  .com_evt  (com_evt),
  .act_oe   (act_oe),
  .act_oen  (act_oen),
  .act_mode (act_mode),
  .com_flag (com_flag)
);

// File: tb/ccp_preload_ctl_tb_top.sv
module ccp_preload_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_oe = 0, wr_oen = 0, pl_en = 0, trig_sel = 0;
  logic sw_com = 0, trig_in = 0, flag_clr = 0;
  logic [1:0] wr_ch = 0;
  logic [2:0] wr_mode = 0;
  logic wr_ready, com_flag;
  logic [NCH-1:0] act_oe, act_oen;
  logic [NCH*3-1:0] act_mode;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_sh [NCH];
  logic [4:0] m_act[NCH];
  logic m_flag = 0, m_tq = 0, m_plq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccp_preload_ctl #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ch(wr_ch), .wr_oe(wr_oe), .wr_oen(wr_oen), .wr_mode(wr_mode),
    .pl_en(pl_en), .trig_sel(trig_sel), .sw_com(sw_com), .trig_in(trig_in),
    .flag_clr(flag_clr), .act_oe(act_oe), .act_oen(act_oen),
    .act_mode(act_mode), .com_flag(com_flag)
  );

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [4:0] dut_word(int c);
    return {act_oe[c], act_oen[c], act_mode[c*3 +: 3]};
  endfunction

  task automatic chk_all(string req);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (dut_word(c) !== m_act[c]) begin
        errors++;
        $display("FAIL %s ch%0d word actual=%b expected=%b", req, c, dut_word(c), m_act[c]);
      end
    end
    checks++;
    if (com_flag !== m_flag) begin
      errors++;
      $display("FAIL %s com_flag actual=%b expected=%b", req, com_flag, m_flag);
    end
  endtask

  // drive one cycle at negedge, advance the model, sample at next negedge
  task automatic cyc(bit wv, int ch, logic [4:0] w, bit pl, bit sel,
                     bit sw, bit trg, bit clr);
    bit evt;
    wr_valid = wv; wr_ch = 2'(ch); {wr_oe, wr_oen, wr_mode} = w;
    pl_en = pl; trig_sel = sel; sw_com = sw; trig_in = trg; flag_clr = clr;
    evt = sw || (sel && trg && !m_tq);
    if (!pl) begin
      if (m_plq) for (int c = 0; c < NCH; c++) m_act[c] = m_sh[c];
      if (wv) m_act[ch] = w;
    end else if (evt) begin
      for (int c = 0; c < NCH; c++) m_act[c] = m_sh[c];
    end
    if (wv) m_sh[ch] = w;
    if (evt) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    m_tq = trg; m_plq = pl;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; sw_com = 0; flag_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_sh[c] = 0; m_act[c] = 0; end
    checks++;
    if (wr_ready !== 1'b1) begin errors++; $display("FAIL R10 ready in reset actual=%b expected=1", wr_ready); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2 / R11: every channel, every word, direct path
    for (int c = 0; c < NCH; c++)
      for (int v = 0; v < 32; v++) begin
        cyc(1, c, 5'(v), 0, 0, 0, 0, 0);
        chk_all("R2_R11");
        checks++;
        if (wr_ready !== 1'b1) begin errors++; $display("FAIL R10 actual=%b expected=1", wr_ready); end
      end

    // R3: buffered writes do not reach active
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    for (int c = 0; c < NCH; c++) begin
      cyc(1, c, 5'((c * 7 + 3) % 32), 1, 0, 0, 0, 0);
      chk_all("R3");
    end

    // R4: trigger edge ignored with select 0, strobe transfers
    cyc(0, 0, 0, 1, 0, 0, 1, 0); chk_all("R4 trig ignored");
    cyc(0, 0, 0, 1, 0, 0, 0, 0); chk_all("R4 trig ignored");
    cyc(0, 0, 0, 1, 0, 1, 0, 0); chk_all("R4 strobe");
    cyc(0, 0, 0, 1, 0, 0, 0, 1); chk_all("R8 clear");

    // R5 / R6: trigger edge transfers once, held level does not repeat
    for (int c = 0; c < NCH; c++) cyc(1, c, 5'((c * 11 + 5) % 32), 1, 1, 0, 0, 0);
    chk_all("R5 pre");
    cyc(0, 0, 0, 1, 1, 0, 1, 0); chk_all("R5 edge");
    for (int c = 0; c < NCH; c++) begin
      cyc(1, c, 5'((c * 13 + 9) % 32), 1, 1, 0, 1, 0);
      chk_all("R6 held high");
    end
    cyc(0, 0, 0, 1, 1, 0, 0, 1); chk_all("R6 low");
    cyc(0, 0, 0, 1, 1, 0, 1, 0); chk_all("R6 new edge");

    // R7: write and strobe together
    for (int v = 0; v < 8; v++) begin
      cyc(1, v % NCH, 5'(v * 4 + 1), 1, 0, 1, 0, 0);
      chk_all("R7 same cycle");
    end
    cyc(0, 0, 0, 1, 0, 1, 0, 0); chk_all("R7 later event");

    // R8: event beats clear in the same cycle
    cyc(0, 0, 0, 1, 0, 0, 0, 1); chk_all("R8 clear");
    cyc(0, 0, 0, 1, 0, 1, 0, 1); chk_all("R8 set wins");
    cyc(0, 0, 0, 1, 0, 0, 0, 0); chk_all("R8 sticky");
    cyc(0, 0, 0, 0, 0, 1, 0, 1); chk_all("R8 event unbuffered");

    // R9: buffering off copies shadow; a concurrent write wins on its channel
    for (int k = 0; k < NCH; k++) begin
      cyc(0, 0, 0, 1, 0, 0, 0, 0);
      for (int c = 0; c < NCH; c++) cyc(1, c, 5'((c * 5 + k * 3 + 2) % 32), 1, 0, 0, 0, 0);
      chk_all("R9 pre");
      cyc(1, k, 5'(31 - k), 0, 0, 0, 0, 0);
      chk_all("R9 fall");
    end

    summary();
    $finish;
  end
endmodule